// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer with Process Tags

This block caches page-table translations so a core can turn a virtual address into a physical one without going to memory on every access. Every entry is compared against the incoming page number at the same time, so any translation may live in any slot. Each entry is tagged with a process identifier. Translations that belong to different tasks can therefore stay resident side by side, and a task switch does not force a full clear.

A lookup presents a virtual address, the current process identifier, a store flag and a user-mode flag. One cycle later the block reports exactly one outcome: a hit carrying the physical address, a miss that traps to a software refill handler, a page fault, or a protection fault. A page fault means the tag matched but the stored page-table entry is invalid. A protection fault means the access is not permitted. Software fills entries through a write port. The target slot is either an explicit index or a pseudo-random index that never lands in the low slots kept for the system. The buffer can be emptied in one cycle, or only the entries of one process identifier can be dropped.

Top module: `tlb_asid_fa`

## Requirements
- R1: After reset every slot is empty, all result outputs are low, and any lookup reports a miss.
- R2: A lookup registered while `lk_valid` is high produces a result with `res_valid` high on the next clock edge. On a hit, `res_paddr` equals the stored 20-bit frame number concatenated with bits 11:0 of the virtual address. Bits 31:12 of the virtual address are the page number.
- R3: A match requires both the page number and the 6-bit process identifier to be equal. The same page number may be resident under two identifiers, and each returns its own frame.
- R4: Each result raises exactly one of `res_hit`, `res_miss`, `res_pfault`, `res_protf`. `res_miss` signals that software must refill the entry.
- R5: When the tag matches but the entry's page-valid bit is 0, the result is a page fault, not a hit.
- R6: Protection bits are bit 0 read, bit 1 write and bit 2 user. A load without read permission, a store without write permission, or a user access without the user bit gives a protection fault.
- R7: `res_dirty` returns the stored dirty bit on a hit. A store that hits sets that bit and changes no other field. A faulting store leaves the bit clear.
- R8: A `flush` pulse empties every slot in one cycle.
- R9: An `inv_en` pulse empties only the slots whose identifier equals `inv_asid`.
- R10: With `wr_use_idx` low, the refill slot comes from a 6-bit LFSR that advances every cycle, with values below 8 folded upward by adding 8, so slots 0 to 7 are never overwritten by random refills.
- R11: With `wr_use_idx` high, the refill goes to `wr_idx`, including slots 0 to 7.
- R12: A lookup in the same cycle as a refill or invalidate sees the contents from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_asid | input | 6 | Process identifier of the access |
| lk_store | input | 1 | Access is a store |
| lk_user | input | 1 | Access is from user mode |
| res_valid | output | 1 | Result present |
| res_hit | output | 1 | Translation found and permitted |
| res_miss | output | 1 | No matching slot; refill trap |
| res_pfault | output | 1 | Matching slot holds an invalid page |
| res_protf | output | 1 | Access denied by protection bits |
| res_dirty | output | 1 | Dirty bit of the hit slot before this access |
| res_paddr | output | 32 | Physical address on a hit, zero otherwise |
| wr_en | input | 1 | Refill write strobe |
| wr_use_idx | input | 1 | 1: use wr_idx, 0: use random slot |
| wr_idx | input | 6 | Explicit refill slot |
| wr_vpn | input | 20 | Page number to store |
| wr_asid | input | 6 | Process identifier to store |
| wr_pte_v | input | 1 | Page-valid bit to store |
| wr_dirty | input | 1 | Dirty bit to store |
| wr_prot | input | 3 | Protection bits to store |
| wr_pfn | input | 20 | Frame number to store |
| flush | input | 1 | Empty all slots |
| inv_en | input | 1 | Empty slots of one identifier |
| inv_asid | input | 6 | Identifier to drop |

## Verification
The bench targets cases where a simple design would go wrong:
- Same page number under two identifiers. A design that ignored the identifier would return the wrong frame or miss.
- A matching entry with an invalid page. A careless design would hit instead of faulting.
- Each protection combination. A design that checked read on stores, or ignored user mode, would let a denied access through.
- Dirty tracking across loads, permitted stores and faulting stores. A design that set the bit on the wrong path, or rewrote other fields, would show a changed dirty bit or physical address.
- Many random refills followed by probes of the reserved slots. An unfolded or mis-folded index would evict them.
- A lookup issued in the same cycle as a refill or invalidate. This exposes a forwarding path that should not exist.
- Per-identifier invalidate. A design that dropped too much would lose the other task's translation.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VPN_W  = 20;
    localparam int OFF_W  = 12;
    localparam int PFN_W  = 20;
    localparam int ASID_W = 6;
    localparam int PROT_W = 3;
    localparam int VA_W   = VPN_W + OFF_W;
    localparam int PA_W   = PFN_W + OFF_W;

    // protection bit positions
    localparam int PR_READ  = 0;
    localparam int PR_WRITE = 1;
    localparam int PR_USER  = 2;

    typedef struct packed {
        logic              present;
        logic              pte_v;
        logic              dirty;
        logic [PROT_W-1:0] prot;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
        logic [PFN_W-1:0]  pfn;
    } tlb_entry_t;
endpackage

// File: rtl/tlb_repl_lfsr.sv
module tlb_repl_lfsr #(
    parameter int IDX_W    = 6,
    parameter int RESERVED = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [IDX_W-1:0] idx
);
    logic [IDX_W-1:0] st_d, st_q;
    logic             fb;

    generate
        if (IDX_W == 6) begin : g_w6
            assign fb = st_q[5] ^ st_q[4];
        end else if (IDX_W == 5) begin : g_w5
            assign fb = st_q[4] ^ st_q[2];
        end else if (IDX_W == 7) begin : g_w7
            assign fb = st_q[6] ^ st_q[5];
        end else begin : g_wx
            assign fb = st_q[IDX_W-1] ^ st_q[0];
        end
    endgenerate

    always_comb begin
        st_d = {st_q[IDX_W-2:0], fb};
        // fold the low reserved range upward so it is never selected
        idx  = (st_q < IDX_W'(RESERVED)) ? st_q + IDX_W'(RESERVED) : st_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= IDX_W'(1);
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tlb_cam.sv
module tlb_cam
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = 6
) (
    input  tlb_entry_t [ENTRIES-1:0] ent,
    input  logic [VPN_W-1:0]         vpn,
    input  logic [ASID_W-1:0]        asid,
    output logic                     hit_any,
    output logic [IDX_W-1:0]         hit_idx
);
    logic [ENTRIES-1:0] hitv;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hitv[g] = ent[g].present && (ent[g].vpn == vpn) && (ent[g].asid == asid);
    end

    // lowest matching slot wins if software ever leaves duplicates
    always_comb begin
        hit_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hitv[i]) hit_idx = IDX_W'(i);
        end
    end

    assign hit_any = |hitv;
endmodule

// File: rtl/tlb_asid_fa.sv
module tlb_asid_fa
    import tlb_pkg::*;
#(
    parameter int ENTRIES  = 64,
    parameter int RESERVED = 8,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_store,
    input  logic              lk_user,
    output logic              res_valid,
    output logic              res_hit,
    output logic              res_miss,
    output logic              res_pfault,
    output logic              res_protf,
    output logic              res_dirty,
    output logic [PA_W-1:0]   res_paddr,
    input  logic              wr_en,
    input  logic              wr_use_idx,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic              wr_pte_v,
    input  logic              wr_dirty,
    input  logic [PROT_W-1:0] wr_prot,
    input  logic [PFN_W-1:0]  wr_pfn,
    input  logic              flush,
    input  logic              inv_en,
    input  logic [ASID_W-1:0] inv_asid
);
    typedef struct packed {
        tlb_entry_t [ENTRIES-1:0] ent;
        logic                     r_valid;
        logic                     r_hit;
        logic                     r_miss;
        logic                     r_pfault;
        logic                     r_protf;
        logic                     r_dirty;
        logic [PA_W-1:0]          r_paddr;
    } state_t;

    state_t             s_d, s_q;
    logic [IDX_W-1:0]   rnd_idx, m_idx, wr_slot;
    logic               m_any, perm_bad, lk_ok;
    logic [ENTRIES-1:0] pres_vec;
    tlb_entry_t         m_ent, new_ent;

    tlb_repl_lfsr #(.IDX_W(IDX_W), .RESERVED(RESERVED)) repl_i (
        .clk   (clk),
        .rst_n (rst_n),
        .idx   (rnd_idx)
    );

    tlb_cam #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) cam_i (
        .ent     (s_q.ent),
        .vpn     (lk_vaddr[VA_W-1:OFF_W]),
        .asid    (lk_asid),
        .hit_any (m_any),
        .hit_idx (m_idx)
    );

    always_comb begin
        m_ent    = s_q.ent[m_idx];
        perm_bad = (lk_store ? !m_ent.prot[PR_WRITE] : !m_ent.prot[PR_READ])
                 || (lk_user && !m_ent.prot[PR_USER]);
        lk_ok    = lk_valid && m_any && m_ent.pte_v && !perm_bad;
        wr_slot  = wr_use_idx ? wr_idx : rnd_idx;

        new_ent.present = 1'b1;
        new_ent.pte_v   = wr_pte_v;
        new_ent.dirty   = wr_dirty;
        new_ent.prot    = wr_prot;
        new_ent.asid    = wr_asid;
        new_ent.vpn     = wr_vpn;
        new_ent.pfn     = wr_pfn;

        s_d = s_q;

        // result from the contents before any update this cycle
        s_d.r_valid  = lk_valid;
        s_d.r_miss   = lk_valid && !m_any;
        s_d.r_pfault = lk_valid && m_any && !m_ent.pte_v;
        s_d.r_protf  = lk_valid && m_any && m_ent.pte_v && perm_bad;
        s_d.r_hit    = lk_ok;
        s_d.r_dirty  = lk_ok && m_ent.dirty;
        s_d.r_paddr  = lk_ok ? {m_ent.pfn, lk_vaddr[OFF_W-1:0]} : '0;

        // only field the lookup path may change
        if (lk_ok && lk_store) s_d.ent[m_idx].dirty = 1'b1;

        for (int i = 0; i < ENTRIES; i++) begin
            if (flush || (inv_en && (s_q.ent[i].asid == inv_asid)))
                s_d.ent[i].present = 1'b0;
            pres_vec[i] = s_q.ent[i].present;
        end

        // a refill takes priority over clears and dirty marking
        if (wr_en) s_d.ent[wr_slot] = new_ent;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign res_valid  = s_q.r_valid;
    assign res_hit    = s_q.r_hit;
    assign res_miss   = s_q.r_miss;
    assign res_pfault = s_q.r_pfault;
    assign res_protf  = s_q.r_protf;
    assign res_dirty  = s_q.r_dirty;
    assign res_paddr  = s_q.r_paddr;
endmodule

// File: rtl/tlb_asid_fa_chk.sv
module tlb_asid_fa_chk
    import tlb_pkg::*;
#(
    parameter int ENTRIES  = 64,
    parameter int RESERVED = 8,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_valid,
    input logic [VA_W-1:0]    lk_vaddr,
    input logic               flush,
    input logic               wr_en,
    input logic [IDX_W-1:0]   rnd_idx,
    input logic [ENTRIES-1:0] pres_vec,
    input logic               res_valid,
    input logic               res_hit,
    input logic               res_miss,
    input logic               res_pfault,
    input logic               res_protf,
    input logic               res_dirty,
    input logic [PA_W-1:0]    res_paddr
);
    p_quiet_when_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> ({res_hit, res_miss, res_pfault, res_protf, res_dirty} == 5'd0 && res_paddr == '0));

    p_result_next_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid);

    p_offset_passthru_r2: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> res_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0]));

    p_single_outcome_r4: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $onehot({res_hit, res_miss, res_pfault, res_protf}));

    p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !wr_en) |=> pres_vec == '0);

    p_random_skips_reserved_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rnd_idx >= IDX_W'(RESERVED));
endmodule

bind tlb_asid_fa tlb_asid_fa_chk #(.ENTRIES(ENTRIES), .RESERVED(RESERVED)) chk_i (.*);

// File: tb/tlb_asid_fa_tb_top.sv
module tlb_asid_fa_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0, lk_store = 1'b0, lk_user = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [5:0]  lk_asid = '0;
    logic        res_valid, res_hit, res_miss, res_pfault, res_protf, res_dirty;
    logic [31:0] res_paddr;
    logic        wr_en = 1'b0, wr_use_idx = 1'b0, wr_pte_v = 1'b0, wr_dirty = 1'b0;
    logic [5:0]  wr_idx = '0, wr_asid = '0;
    logic [19:0] wr_vpn = '0, wr_pfn = '0;
    logic [2:0]  wr_prot = '0;
    logic        flush = 1'b0, inv_en = 1'b0;
    logic [5:0]  inv_asid = '0;

    int total = 0;
    int bad   = 0;

    always #2.5ns clk = ~clk;

    tlb_asid_fa dut_i (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_asid(lk_asid),
        .lk_store(lk_store), .lk_user(lk_user),
        .res_valid(res_valid), .res_hit(res_hit), .res_miss(res_miss),
        .res_pfault(res_pfault), .res_protf(res_protf), .res_dirty(res_dirty),
        .res_paddr(res_paddr),
        .wr_en(wr_en), .wr_use_idx(wr_use_idx), .wr_idx(wr_idx), .wr_vpn(wr_vpn),
        .wr_asid(wr_asid), .wr_pte_v(wr_pte_v), .wr_dirty(wr_dirty),
        .wr_prot(wr_prot), .wr_pfn(wr_pfn),
        .flush(flush), .inv_en(inv_en), .inv_asid(inv_asid)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // flags order: hit, miss, pfault, protf
    task automatic expect_res(string req, logic [3:0] flags, logic [31:0] pa, bit d);
        check(req, "res_valid", 32'(res_valid), 32'd1);
        check(req, "outcome", 32'({res_hit, res_miss, res_pfault, res_protf}), 32'(flags));
        if (flags[3]) begin
            check(req, "paddr", res_paddr, pa);
            check(req, "dirty", 32'(res_dirty), 32'(d));
        end
    endtask

    task automatic drive_lookup(logic [19:0] vpn, logic [11:0] off, logic [5:0] asid, bit st, bit us);
        lk_valid = 1'b1; lk_vaddr = {vpn, off}; lk_asid = asid; lk_store = st; lk_user = us;
    endtask

    task automatic drive_refill(bit use_idx, logic [5:0] idx, logic [19:0] vpn, logic [5:0] asid,
                                bit pv, bit d, logic [2:0] prot, logic [19:0] pfn);
        wr_en = 1'b1; wr_use_idx = use_idx; wr_idx = idx; wr_vpn = vpn; wr_asid = asid;
        wr_pte_v = pv; wr_dirty = d; wr_prot = prot; wr_pfn = pfn;
    endtask

    task automatic release_all();
        lk_valid = 1'b0; lk_store = 1'b0; lk_user = 1'b0;
        wr_en = 1'b0; flush = 1'b0; inv_en = 1'b0;
    endtask

    task automatic refill(bit use_idx, logic [5:0] idx, logic [19:0] vpn, logic [5:0] asid,
                          bit pv, bit d, logic [2:0] prot, logic [19:0] pfn);
        @(negedge clk);
        drive_refill(use_idx, idx, vpn, asid, pv, d, prot, pfn);
        @(posedge clk); #1ns;
        release_all();
    endtask

    task automatic lookup(logic [19:0] vpn, logic [11:0] off, logic [5:0] asid, bit st, bit us);
        @(negedge clk);
        drive_lookup(vpn, off, asid, st, us);
        @(posedge clk); #1ns;
        release_all();
    endtask

    task automatic t_reset();
        check("R1", "res_valid after reset", 32'(res_valid), 32'd0);
        check("R1", "flags after reset", 32'({res_hit, res_miss, res_pfault, res_protf, res_dirty}), 32'd0);
        lookup(20'h12345, 12'h678, 6'd1, 1'b0, 1'b0);
        expect_res("R1", 4'b0100, 32'd0, 1'b0);
    endtask

    task automatic t_basic();
        refill(1'b1, 6'd10, 20'h12345, 6'd3, 1'b1, 1'b0, 3'b111, 20'hABCDE);
        lookup(20'h12345, 12'h9F0, 6'd3, 1'b0, 1'b0);
        expect_res("R2", 4'b1000, 32'hABCDE9F0, 1'b0);
        lookup(20'h12345, 12'h9F0, 6'd4, 1'b0, 1'b0);
        expect_res("R3", 4'b0100, 32'd0, 1'b0);
        lookup(20'h12346, 12'h000, 6'd3, 1'b0, 1'b0);
        expect_res("R4", 4'b0100, 32'd0, 1'b0);
        refill(1'b1, 6'd11, 20'h12345, 6'd4, 1'b1, 1'b0, 3'b111, 20'h11111);
        lookup(20'h12345, 12'h004, 6'd4, 1'b0, 1'b0);
        expect_res("R3", 4'b1000, 32'h11111004, 1'b0);
        lookup(20'h12345, 12'h004, 6'd3, 1'b0, 1'b0);
        expect_res("R3", 4'b1000, 32'hABCDE004, 1'b0);
    endtask

    task automatic t_pfault();
        refill(1'b1, 6'd12, 20'h00AAA, 6'd3, 1'b0, 1'b0, 3'b111, 20'h22222);
        lookup(20'h00AAA, 12'h010, 6'd3, 1'b0, 1'b0);
        expect_res("R5", 4'b0010, 32'd0, 1'b0);
    endtask

    task automatic t_prot();
        refill(1'b1, 6'd13, 20'h00BBB, 6'd3, 1'b1, 1'b0, 3'b001, 20'h33333);
        lookup(20'h00BBB, 12'h020, 6'd3, 1'b0, 1'b0);
        expect_res("R6", 4'b1000, 32'h33333020, 1'b0);
        lookup(20'h00BBB, 12'h020, 6'd3, 1'b1, 1'b0);
        expect_res("R6", 4'b0001, 32'd0, 1'b0);
        lookup(20'h00BBB, 12'h020, 6'd3, 1'b0, 1'b1);
        expect_res("R6", 4'b0001, 32'd0, 1'b0);
        refill(1'b1, 6'd14, 20'h00CCC, 6'd3, 1'b1, 1'b0, 3'b110, 20'h44444);
        lookup(20'h00CCC, 12'h030, 6'd3, 1'b0, 1'b1);
        expect_res("R6", 4'b0001, 32'd0, 1'b0);
        lookup(20'h00CCC, 12'h030, 6'd3, 1'b1, 1'b1);
        expect_res("R6", 4'b1000, 32'h44444030, 1'b0);
    endtask

    task automatic t_dirty();
        lookup(20'h12345, 12'h100, 6'd3, 1'b0, 1'b0);
        expect_res("R7", 4'b1000, 32'hABCDE100, 1'b0);
        lookup(20'h12345, 12'h100, 6'd3, 1'b1, 1'b0);
        expect_res("R7", 4'b1000, 32'hABCDE100, 1'b0);
        lookup(20'h12345, 12'h200, 6'd3, 1'b0, 1'b0);
        expect_res("R7", 4'b1000, 32'hABCDE200, 1'b1);
        // a denied store must not mark the slot
        lookup(20'h00BBB, 12'h040, 6'd3, 1'b1, 1'b0);
        expect_res("R7", 4'b0001, 32'd0, 1'b0);
        lookup(20'h00BBB, 12'h040, 6'd3, 1'b0, 1'b0);
        expect_res("R7", 4'b1000, 32'h33333040, 1'b0);
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        drive_lookup(20'h0DDDD, 12'h050, 6'd3, 1'b0, 1'b0);
        drive_refill(1'b1, 6'd20, 20'h0DDDD, 6'd3, 1'b1, 1'b0, 3'b111, 20'h0D0D0);
        @(posedge clk); #1ns;
        release_all();
        expect_res("R12", 4'b0100, 32'd0, 1'b0);
        lookup(20'h0DDDD, 12'h050, 6'd3, 1'b0, 1'b0);
        expect_res("R12", 4'b1000, 32'h0D0D0050, 1'b0);
        @(negedge clk);
        drive_lookup(20'h12345, 12'h060, 6'd3, 1'b0, 1'b0);
        inv_en = 1'b1; inv_asid = 6'd3;
        @(posedge clk); #1ns;
        release_all();
        expect_res("R12", 4'b1000, 32'hABCDE060, 1'b1);
        lookup(20'h12345, 12'h060, 6'd3, 1'b0, 1'b0);
        expect_res("R9", 4'b0100, 32'd0, 1'b0);
        lookup(20'h0DDDD, 12'h060, 6'd3, 1'b0, 1'b0);
        expect_res("R9", 4'b0100, 32'd0, 1'b0);
        lookup(20'h12345, 12'h060, 6'd4, 1'b0, 1'b0);
        expect_res("R9", 4'b1000, 32'h11111060, 1'b0);
    endtask

    task automatic t_reserved();
        for (int i = 0; i < 8; i++)
            refill(1'b1, 6'(i), 20'h70000 + 20'(i), 6'd0, 1'b1, 1'b0, 3'b111, 20'h50000 + 20'(i));
        for (int k = 0; k < 120; k++)
            refill(1'b0, 6'd0, 20'h80000 + 20'(k), 6'd1, 1'b1, 1'b0, 3'b111, 20'h60000 + 20'(k));
        lookup(20'h80000 + 20'd119, 12'h070, 6'd1, 1'b0, 1'b0);
        expect_res("R10", 4'b1000, {20'h60000 + 20'd119, 12'h070}, 1'b0);
        for (int i = 0; i < 8; i++) begin
            lookup(20'h70000 + 20'(i), 12'h0A0, 6'd0, 1'b0, 1'b0);
            expect_res("R10 R11", 4'b1000, {20'h50000 + 20'(i), 12'h0A0}, 1'b0);
        end
    endtask

    task automatic t_flush();
        @(negedge clk);
        flush = 1'b1;
        @(posedge clk); #1ns;
        release_all();
        lookup(20'h70000, 12'h0B0, 6'd0, 1'b0, 1'b0);
        expect_res("R8", 4'b0100, 32'd0, 1'b0);
        lookup(20'h80000 + 20'd119, 12'h0B0, 6'd1, 1'b0, 1'b0);
        expect_res("R8", 4'b0100, 32'd0, 1'b0);
        lookup(20'h12345, 12'h0B0, 6'd4, 1'b0, 1'b0);
        expect_res("R8", 4'b0100, 32'd0, 1'b0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1ns;
        t_reset();
        t_basic();
        t_pfault();
        t_prot();
        t_dirty();
        t_same_cycle();
        t_reserved();
        t_flush();
        repeat (2) @(posedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL all watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule